// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit counting channel of the kind grouped three to a timer. Each rising edge of its counting clock is one tick. A load strobe brings in a new initial count together with a counting mode. From then on the channel tracks the ticks elapsed since that load, or since the last gate retrigger. From that elapsed value it derives an output waveform and a readable count. Surrounding logic latches the readable count and hands it to software.

Six behaviours are available:

- a one-time terminal event;
- a gate-triggered one-shot;
- a periodic rate pulse;
- a square wave;
- a strobe started by software;
- a strobe started by hardware.

The gate input either pauses counting or restarts it from the loaded value on a rising edge, depending on the mode. Mode codes 6 and 7 act as codes 2 and 3. A loaded value of zero stands for a period of 65536 ticks.

Top module: `ivt_channel`

## Requirements
- R1: In modes 0 and 1 the output is 0 from the load until N counted ticks have elapsed. It then becomes 1 and remains 1 until the next load or retrigger.
- R2: In mode 2 the period is N ticks. The output is 1 for exactly one tick at every nonzero multiple of N elapsed ticks, and 0 at all other times.
- R3: In mode 3 the output is 1 while the phase within the period is below (N+1)/2, and 0 for the rest of the period. An odd N therefore gives the extra tick to the high half.
- R4: In mode 3 the readable count is N minus (2 times the phase, modulo N). It drops by two per tick and wraps within the period.
- R5: In modes 4 and 5 the output is 1 for exactly one tick, when the elapsed ticks equal N. It does not fire again until a reload or retrigger.
- R6: In modes 0, 1, 4 and 5 the readable count is (loaded value minus elapsed ticks) modulo 65536, so it wraps past zero. In mode 2 it is N minus (elapsed modulo N).
- R7: In modes 1, 2, 3 and 5 a gate rising edge sets the elapsed count back to zero. In modes 0 and 4 a gate rising edge has no restart effect.
- R8: In modes 0, 2, 3 and 4 a tick is not counted while the gate is low. In modes 1 and 5 a low gate does not pause counting.
- R9: A loaded value of 0 behaves as N = 65536.
- R10: After reset the channel is in mode 3 with N = 65536, the output is 1 and the readable count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; one rising edge is one tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_stb | input | 1 | Load strobe: take ld_mode and ld_value at this edge |
| ld_mode | input | 3 | Counting mode code, 0 to 7 |
| ld_value | input | 16 | Initial count, 0 meaning 65536 |
| gate_in | input | 1 | Gate: pauses or retriggers counting, depending on mode |
| cnt_out | output | 1 | Channel output waveform |
| cnt_value | output | 16 | Current readable count |

## Verification
The output and the readable count are both decoded from the registered phase, so a wrong phase, period or progress flag shows on cnt_value in the very next cycle. A one-shot whose saturation is wrong fires a second strobe, and that surfaces only about one period later. The bench compares both outputs against values computed from the elapsed tick count. It does this every few cycles across all six modes, during gate pauses and retriggers, and through the 16-bit wrap and the 65536-tick period.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_SQUARE  = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5
    } ivt_mode_e;

    // codes 6 and 7 fold onto the periodic modes
    function automatic ivt_mode_e fold_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11) return ivt_mode_e'({1'b0, code[1:0]});
        return ivt_mode_e'(code);
    endfunction

    function automatic logic is_periodic(input ivt_mode_e m);
        return (m == MD_RATE) || (m == MD_SQUARE);
    endfunction

    function automatic logic gate_restarts(input ivt_mode_e m);
        return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTB);
    endfunction

    function automatic logic gate_pauses(input ivt_mode_e m);
        return (m == MD_TERM) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_SWSTB);
    endfunction

endpackage

// File: rtl/ivt_gate_edge.sv
module ivt_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    output logic gate_rise
);
    logic gate_d, gate_q;

    always_comb begin
        gate_d    = gate_in;
        gate_rise = gate_in & ~gate_q;
    end

    // reset high so a gate already high at reset release is not a retrigger
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate_d;
    end

endmodule

// File: rtl/ivt_decode.sv
module ivt_decode
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  ivt_mode_e        mode,
    input  logic [CNT_W:0]   period,
    input  logic [CNT_W:0]   phase,
    input  logic [CNT_W-1:0] down,
    input  logic             run,
    output logic             wave,
    output logic [CNT_W-1:0] value
);
    localparam int PW = CNT_W + 1;

    logic [PW-1:0] half;
    logic [PW:0]   dbl;
    logic [PW:0]   dbl_mod;
    logic [PW-1:0] rate_val;
    logic [PW:0]   sq_val;

    always_comb begin
        half     = (period + {{CNT_W{1'b0}}, 1'b1}) >> 1;
        dbl      = {phase, 1'b0};
        dbl_mod  = (dbl >= {1'b0, period}) ? dbl - {1'b0, period} : dbl;
        rate_val = period - phase;
        sq_val   = {1'b0, period} - dbl_mod;
        case (mode)
            MD_RATE: begin
                wave  = (phase == '0) && run;
                value = rate_val[CNT_W-1:0];
            end
            MD_SQUARE: begin
                wave  = phase < half;
                value = sq_val[CNT_W-1:0];
            end
            MD_SWSTB, MD_HWSTB: begin
                wave  = phase == period;
                value = down;
            end
            default: begin
                wave  = phase >= period;
                value = down;
            end
        endcase
    end

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_stb,
    input  logic [2:0]       ld_mode,
    input  logic [CNT_W-1:0] ld_value,
    input  logic             gate_in,
    output logic             cnt_out,
    output logic [CNT_W-1:0] cnt_value
);
    localparam logic [CNT_W:0] FULL_PERIOD = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE         = {{CNT_W{1'b0}}, 1'b1};

    typedef struct packed {
        ivt_mode_e        mode;
        logic [CNT_W:0]   period;
        logic [CNT_W:0]   phase;
        logic [CNT_W-1:0] down;
        logic             run;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     gate_rise;
    logic     cnt_en;

    ivt_gate_edge u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_in  (gate_in),
        .gate_rise(gate_rise)
    );

    always_comb begin
        st_d   = st_q;
        cnt_en = gate_in || !gate_pauses(st_q.mode);
        if (ld_stb) begin
            st_d.mode   = fold_mode(ld_mode);
            st_d.period = (ld_value == '0) ? FULL_PERIOD : {1'b0, ld_value};
            st_d.phase  = '0;
            st_d.down   = ld_value;
            st_d.run    = 1'b0;
        end else if (gate_rise && gate_restarts(st_q.mode)) begin
            st_d.phase = '0;
            st_d.down  = st_q.period[CNT_W-1:0];
            st_d.run   = 1'b0;
        end else if (cnt_en) begin
            st_d.down = st_q.down - 1'b1;
            st_d.run  = 1'b1;
            if (is_periodic(st_q.mode))
                st_d.phase = (st_q.phase == st_q.period - ONE) ? '0 : st_q.phase + ONE;
            else if (st_q.phase <= st_q.period)
                st_d.phase = st_q.phase + ONE;  // saturates at period+1
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MD_SQUARE;
            st_q.period <= FULL_PERIOD;
            st_q.phase  <= '0;
            st_q.down   <= '0;
            st_q.run    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    ivt_decode #(.CNT_W(CNT_W)) u_dec (
        .mode  (st_q.mode),
        .period(st_q.period),
        .phase (st_q.phase),
        .down  (st_q.down),
        .run   (st_q.run),
        .wave  (cnt_out),
        .value (cnt_value)
    );

    a_r1_low_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && (ld_mode == 3'd0 || ld_mode == 3'd1)) |=> !cnt_out);

    a_r1_stays_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MD_TERM || st_q.mode == MD_ONESHOT) && cnt_out && !ld_stb
         && !(gate_rise && st_q.mode == MD_ONESHOT)) |=> cnt_out);

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MD_SWSTB || st_q.mode == MD_HWSTB) && cnt_out && !ld_stb) |=> !cnt_out);

    a_r2_one_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_RATE && cnt_out && gate_in && !ld_stb && st_q.period != ONE) |=> !cnt_out);

    a_r8_paused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_TERM && !gate_in && !ld_stb) |=> $stable(cnt_value));

endmodule

// File: tb/ivt_channel_bench.sv
module ivt_channel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_stb = 1'b0;
    logic [2:0]  ld_mode = 3'd0;
    logic [15:0] ld_value = 16'd0;
    logic        gate_in = 1'b1;
    logic        cnt_out;
    logic [15:0] cnt_value;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        logic        exp_out;
        logic [15:0] exp_val;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    ivt_channel u_ivt_channel (
        .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_mode(ld_mode),
        .ld_value(ld_value), .gate_in(gate_in), .cnt_out(cnt_out), .cnt_value(cnt_value)
    );

    task automatic expect_now(input string tag, input logic o, input logic [15:0] v);
        exp_t e;
        e.tag = tag; e.exp_out = o; e.exp_val = v;
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [2:0] m, input logic [15:0] v);
        @(negedge clk);
        ld_stb = 1'b1; ld_mode = m; ld_value = v;
        @(negedge clk);
        ld_stb = 1'b0;
    endtask

    // monitor: compares once outputs settle after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (cnt_out !== e.exp_out || cnt_value !== e.exp_val) begin
                    n_fail++;
                    $display("FAIL %s: out=%0b value=%0d expected out=%0b value=%0d",
                             e.tag, cnt_out, cnt_value, e.exp_out, e.exp_val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        step(2);
        expect_now("R10 reset state", 1'b1, 16'd0);
        step(1);
        rst_n = 1'b1;
        step(2);
        expect_now("R10 mode3 full period after reset", 1'b1, 16'd65532);

        // mode 0: terminal event, wrap
        load(3'd0, 16'd5);
        expect_now("R1 mode0 after load", 1'b0, 16'd5);
        step(4); expect_now("R1 mode0 before terminal", 1'b0, 16'd1);
        step(1); expect_now("R1 mode0 terminal", 1'b1, 16'd0);
        step(1); expect_now("R6 mode0 wrap", 1'b1, 16'hFFFF);

        // mode 0: gate pause, and no restart on rise
        load(3'd0, 16'd10);
        step(2); expect_now("R8 mode0 counting", 1'b0, 16'd8);
        gate_in = 1'b0;
        step(3); expect_now("R8 mode0 paused", 1'b0, 16'd8);
        gate_in = 1'b1;
        step(1); expect_now("R7 mode0 rise no restart", 1'b0, 16'd7);

        // mode 1: low gate keeps counting, rise restarts
        load(3'd1, 16'd4);
        step(2); expect_now("R1 mode1 counting", 1'b0, 16'd2);
        gate_in = 1'b0;
        step(1); expect_now("R8 mode1 low gate counts", 1'b0, 16'd1);
        gate_in = 1'b1;
        step(1); expect_now("R7 mode1 retrigger", 1'b0, 16'd4);
        step(4); expect_now("R1 mode1 terminal", 1'b1, 16'd0);
        step(3); expect_now("R1 mode1 stays high", 1'b1, 16'd65533);

        // mode 2: rate pulse
        load(3'd2, 16'd4);
        expect_now("R2 mode2 start", 1'b0, 16'd4);
        step(1); expect_now("R6 mode2 count", 1'b0, 16'd3);
        step(2); expect_now("R6 mode2 count low", 1'b0, 16'd1);
        step(1); expect_now("R2 mode2 boundary pulse", 1'b1, 16'd4);
        step(1); expect_now("R2 mode2 pulse ends", 1'b0, 16'd3);
        gate_in = 1'b0;
        step(2); expect_now("R8 mode2 paused", 1'b0, 16'd3);
        gate_in = 1'b1;
        step(1); expect_now("R7 mode2 retrigger", 1'b0, 16'd4);

        // mode 3 odd and even periods
        load(3'd3, 16'd5);
        expect_now("R3 mode3 odd ph0", 1'b1, 16'd5);
        step(1); expect_now("R4 mode3 odd ph1", 1'b1, 16'd3);
        step(1); expect_now("R3 mode3 odd ph2 high", 1'b1, 16'd1);
        step(1); expect_now("R3 mode3 odd ph3 low", 1'b0, 16'd4);
        step(1); expect_now("R4 mode3 odd ph4", 1'b0, 16'd2);
        step(1); expect_now("R3 mode3 odd wrap", 1'b1, 16'd5);
        load(3'd7, 16'd6);
        step(2); expect_now("R4 mode3 even ph2", 1'b1, 16'd2);
        step(1); expect_now("R3 mode3 even ph3 low", 1'b0, 16'd6);
        gate_in = 1'b0;
        step(2); expect_now("R8 mode3 paused", 1'b0, 16'd6);
        gate_in = 1'b1;
        step(1); expect_now("R7 mode3 retrigger", 1'b1, 16'd6);

        // mode 4: single strobe, gate pause
        load(3'd4, 16'd3);
        expect_now("R5 mode4 start", 1'b0, 16'd3);
        step(3); expect_now("R5 mode4 strobe", 1'b1, 16'd0);
        step(1); expect_now("R5 mode4 strobe ends", 1'b0, 16'hFFFF);
        step(10); expect_now("R5 mode4 no repeat", 1'b0, 16'd65525);
        load(3'd4, 16'd3);
        gate_in = 1'b0;
        step(3); expect_now("R8 mode4 paused", 1'b0, 16'd3);
        gate_in = 1'b1;
        step(1); expect_now("R7 mode4 rise no restart", 1'b0, 16'd2);

        // mode 5: retrigger gives a new strobe
        load(3'd5, 16'd2);
        step(2); expect_now("R5 mode5 strobe", 1'b1, 16'd0);
        step(1); expect_now("R5 mode5 strobe ends", 1'b0, 16'hFFFF);
        gate_in = 1'b0;
        step(1);
        gate_in = 1'b1;
        step(1); expect_now("R7 mode5 retrigger", 1'b0, 16'd2);
        step(2); expect_now("R5 mode5 second strobe", 1'b1, 16'd0);

        // zero means 65536
        load(3'd0, 16'd0);
        step(65535); expect_now("R9 zero load just before end", 1'b0, 16'd1);
        step(1); expect_now("R9 zero load terminal", 1'b1, 16'd0);

        step(2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule